// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a run of words between one I/O device and memory without the CPU touching each word. A device that wants service raises its request line; while the engine is not armed, it passes that request on to the CPU as a service request. The CPU then loads a start address, a word count, a burst hold limit and a control word. The control word holds the direction, the bus-usage mode and the arm bit.

Once armed, the engine asks for the system bus. It places nothing on the memory port until the CPU grants the bus. It then moves one word per usable cycle over a single-cycle memory port. Data is steered combinationally between the device and memory according to the direction.

There are two bus-usage modes. In cycle-stealing mode, a word moves only in cycles that the CPU marks as idle. In burst mode, the engine holds the bus across cycles until one of three things happens: the count runs out, a programmable hold limit is reached, or a higher-priority interrupt forces it to let go. After a forced release it gives the bus back for one cycle and asks again. When the count reaches zero, a sticky done flag drives the interrupt output.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: `svc_req` equals `dev_req` while the engine is not armed, and is low while it is armed.
- R2: Register select codes are 0 = control, 1 = start address, 2 = word count and 3 = hold limit. Control bits are bit 0 = arm, bit 1 = direction and bit 2 = burst mode. With direction 1 (device to memory), each moved word has `mem_we`=1 and `mem_wdata`=`dev_rdata`. With direction 0 (memory to device), each moved word has `mem_we`=0 and `dev_wdata`=`mem_rdata`. Every moved word pulses `dev_ack`.
- R3: Arming with a non-zero count raises `bus_req` on the next cycle. `mem_en` is never high unless both `bus_req` and `bus_grant` are high.
- R4: In cycle-stealing mode, exactly one word moves in each cycle where `bus_req`, `bus_grant`, `bus_idle` and `dev_req` are all high, and none moves in any other cycle.
- R5: In burst mode, one word moves in every cycle where the bus is held, granted and `dev_req` is high; `bus_idle` is ignored. A cycle with `irq_hi` high while the bus is granted moves no word. `bus_req` then drops for exactly one cycle and is raised again.
- R6: Each moved word is placed at the current address on `mem_addr`. The address then increments by one, wrapping at its width, and the count decrements by one.
- R7: The move that takes the count to zero does three things: it drops `bus_req`, disarms the engine and sets the sticky `irq`. Arming with a count of zero sets `irq` at once, with no bus request. Any control write while disarmed clears `irq`.
- R8: With a hold limit L greater than 0, after L words in one bus tenure the engine drops `bus_req` for one cycle and then re-requests. L = 0 means no limit. A burst of N words therefore completes N + floor((N-1)/L) cycles after arming.
- R9: While armed, every register write is ignored, except a control write with the arm bit at 0. That write disarms the engine and drops `bus_req` from the next cycle on. A word moved in the same cycle as that write still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_sel | input | 2 | Register select (R2 codes) |
| reg_wdata | input | REG_W | Register write data |
| dev_req | input | 1 | Device wants a transfer / is ready for a word |
| dev_ack | output | 1 | A word is moved this cycle |
| svc_req | output | 1 | Setup request to the CPU |
| dev_rdata | input | DATA_W | Word from the device |
| dev_wdata | output | DATA_W | Word to the device |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | Bus acknowledge from the CPU |
| bus_idle | input | 1 | CPU leaves this bus cycle unused |
| irq_hi | input | 1 | Higher-priority interrupt forcing bus release |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address (zero when idle) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| st_enable | output | 1 | Engine armed |
| st_addr | output | ADDR_W | Current address register |
| st_count | output | CNT_W | Remaining word count |
| irq | output | 1 | Sticky completion flag |

## Verification
Two functions can land on the same clock edge: the final word move, and a CPU control write that disarms the engine. The bench provokes this by arming a one-word burst with the bus granted, then asserting the disarm write in the very cycle in which that word moves. The result is judged from the next cycle's ports. The word must have been strobed, the address must have advanced by one, and the count must be zero. The completion flag must still be set, and the engine must be disarmed.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_HOLD  = 2'd3
    } reg_sel_e;

    localparam int CTL_ARM   = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_BURST = 2;

endpackage

// File: rtl/dma_hold_timer.sv
module dma_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [HOLD_W-1:0] limit,
    output logic              expire
);
    logic [HOLD_W-1:0] cnt_d, cnt_q;
    logic [HOLD_W-1:0] cnt_nx;

    assign cnt_nx = HOLD_W'(cnt_q + 1'b1);
    assign expire = inc && (limit != '0) && (cnt_nx == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = expire ? '0 : cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit)); // R8

endmodule

// File: rtl/dma_port_steer.sv
module dma_port_steer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              active,
    input  logic              dir_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata
);
    always_comb begin
        mem_we    = active && dir_in;
        mem_addr  = active ? addr : '0;
        mem_wdata = (active && dir_in)  ? dev_rdata : '0;
        dev_wdata = (active && !dir_in) ? mem_rdata : '0;
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int HOLD_W = 4,
    parameter int DATA_W = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              svc_req,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_idle,
    input  logic              irq_hi,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              st_enable,
    output logic [ADDR_W-1:0] st_addr,
    output logic [CNT_W-1:0]  st_count,
    output logic              irq
);
    typedef struct packed {
        logic              enable;
        logic              dir_in;
        logic              burst;
        logic              bus_req;
        logic              gap;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [HOLD_W-1:0] hold_lim;
    } ctl_t;

    ctl_t     s_d, s_q;
    reg_sel_e sel;
    logic     granted, move, expire, hold_clr, release_bus;

    assign sel      = reg_sel_e'(reg_sel);
    assign granted  = s_q.bus_req && bus_grant;
    assign move     = granted && s_q.enable && dev_req &&
                      (s_q.burst ? !irq_hi : bus_idle);
    assign hold_clr = !s_q.bus_req;

    dma_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hold_clr),
        .inc    (move),
        .limit  (s_q.hold_lim),
        .expire (expire)
    );

    dma_port_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
        .active    (move),
        .dir_in    (s_q.dir_in),
        .addr      (s_q.addr),
        .dev_rdata (dev_rdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dev_wdata (dev_wdata)
    );

    always_comb begin
        release_bus = s_q.burst && s_q.enable && granted && (irq_hi || expire);
        s_d = s_q;

        if (move) begin
            s_d.addr  = ADDR_W'(s_q.addr + 1'b1);
            s_d.count = CNT_W'(s_q.count - 1'b1);
        end
        if (release_bus) begin
            s_d.bus_req = 1'b0;
            s_d.gap     = 1'b1;
        end
        if (s_q.gap) begin
            s_d.gap     = 1'b0;
            s_d.bus_req = s_q.enable;
        end
        if (move && (s_q.count == CNT_W'(1))) begin
            s_d.enable  = 1'b0;
            s_d.bus_req = 1'b0;
            s_d.gap     = 1'b0;
            s_d.done    = 1'b1;
        end

        if (reg_wr) begin
            if (!s_q.enable) begin
                case (sel)
                    SEL_CTRL: begin
                        s_d.dir_in = reg_wdata[CTL_DIR];
                        s_d.burst  = reg_wdata[CTL_BURST];
                        s_d.done   = 1'b0;
                        if (reg_wdata[CTL_ARM]) begin
                            if (s_q.count == '0) begin
                                s_d.done = 1'b1;
                            end else begin
                                s_d.enable  = 1'b1;
                                s_d.bus_req = 1'b1;
                                s_d.gap     = 1'b0;
                            end
                        end
                    end
                    SEL_ADDR:  s_d.addr     = reg_wdata[ADDR_W-1:0];
                    SEL_COUNT: s_d.count    = reg_wdata[CNT_W-1:0];
                    SEL_HOLD:  s_d.hold_lim = reg_wdata[HOLD_W-1:0];
                    default:   s_d.addr     = s_q.addr;
                endcase
            end else if ((sel == SEL_CTRL) && !reg_wdata[CTL_ARM]) begin
                s_d.enable  = 1'b0;
                s_d.bus_req = 1'b0;
                s_d.gap     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dev_ack   = move;
    assign mem_en    = move;
    assign svc_req   = dev_req && !s_q.enable;
    assign bus_req   = s_q.bus_req;
    assign st_enable = s_q.enable;
    assign st_addr   = s_q.addr;
    assign st_count  = s_q.count;
    assign irq       = s_q.done;

    AST_NO_BUS_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bus_req && bus_grant)); // R3
    AST_STEAL_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !s_q.burst) |-> bus_idle); // R4
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.burst && s_q.enable && granted && irq_hi) |=> !bus_req); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (st_addr == ADDR_W'($past(st_addr) + 1'b1))); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (st_count == CNT_W'($past(st_count) - 1'b1))); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!bus_req && !st_enable)); // R7
    AST_GAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_req) && st_enable) |=> (bus_req || !st_enable)); // R8
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && st_enable && (reg_sel == 2'd0) && !reg_wdata[CTL_ARM])
        |=> (!st_enable && !bus_req)); // R9

endmodule

// File: tb/dma_xfer_ctrl_test.sv
module dma_xfer_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int HW = 4;
    localparam int DW = 16;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic          dev_req = 1'b0;
    logic          dev_ack, svc_req;
    logic [DW-1:0] dev_rdata = '0;
    logic [DW-1:0] dev_wdata;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          bus_idle = 1'b0;
    logic          irq_hi = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          st_enable;
    logic [AW-1:0] st_addr;
    logic [CW-1:0] st_count;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    dma_xfer_ctrl #(.ADDR_W(AW), .CNT_W(CW), .HOLD_W(HW), .DATA_W(DW), .REG_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .svc_req(svc_req), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .bus_req(bus_req), .bus_grant(bus_grant), .bus_idle(bus_idle),
        .irq_hi(irq_hi), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .st_enable(st_enable),
        .st_addr(st_addr), .st_count(st_count), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [RW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_xfer(input int start, input int n, input int lim,
                            input bit burst, input bit dir_in);
        int moves = 0;
        int addr_err = 0;
        int data_err = 0;
        int idle_err = 0;
        int done_at = -1;
        int exp_cyc = 0;
        int seen = 0;
        bus_grant = 1'b1; dev_req = 1'b1; irq_hi = 1'b0;
        wr(2'd1, RW'(start));
        wr(2'd2, RW'(n));
        wr(2'd3, RW'(lim));
        wr(2'd0, RW'({burst, dir_in, 1'b1}));
        for (int k = 0; k < 200; k++) begin
            if (k > 0) @(negedge clk);
            bus_idle  = burst ? 1'b0 : ((k % 3) != 0);
            dev_rdata = DW'(16'h5A00 + k);
            mem_rdata = DW'(16'hC300 + k);
            #1;
            if (irq) begin done_at = k; break; end
            if (mem_en) begin
                if (mem_addr != AW'(start + moves)) addr_err++;
                if (!dev_ack) data_err++;
                if (dir_in) begin
                    if (!mem_we || mem_wdata != dev_rdata) data_err++;
                end else begin
                    if (mem_we || dev_wdata != mem_rdata) data_err++;
                end
                if (!burst && !bus_idle) idle_err++;
                moves++;
            end
        end
        if (burst) begin
            exp_cyc = n + ((lim == 0) ? 0 : (n - 1) / lim);
            chk(done_at == exp_cyc, "R5/R8 burst completion cycle", done_at, exp_cyc);
        end else begin
            for (int i = 0; i < 200; i++) begin
                if ((i % 3) != 0) seen++;
                if (seen == n) begin exp_cyc = i + 1; break; end
            end
            chk(done_at == exp_cyc, "R4 steal completion cycle", done_at, exp_cyc);
            chk(idle_err == 0, "R4 move in busy cycle", idle_err, 0);
        end
        chk(moves == n, "R6 words moved", moves, n);
        chk(addr_err == 0, "R6 address sequence", addr_err, 0);
        chk(data_err == 0, "R2 data steering", data_err, 0);
        chk(st_addr == AW'(start + n), "R6 final address", st_addr, AW'(start + n));
        chk(st_count == 0, "R7 final count", st_count, 0);
        chk(!st_enable && !bus_req, "R7 disarm and release", {st_enable, bus_req}, 0);
    endtask

    initial begin
        int moves;
        int done_at;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!irq && !bus_req && !st_enable && !mem_en && st_count == 0,
            "R7 reset state", {irq, bus_req, st_enable, mem_en}, 0);

        // R1: service request forwarding
        dev_req = 1'b1; #1;
        chk(svc_req == 1'b1, "R1 svc_req idle", svc_req, 1);
        dev_req = 1'b0; #1;
        chk(svc_req == 1'b0, "R1 svc_req no request", svc_req, 0);

        // R3 / R9: bus withheld, writes while armed ignored, then abort
        bus_grant = 1'b0; dev_req = 1'b1;
        wr(2'd1, 16'd40); wr(2'd2, 16'd3); wr(2'd3, 16'd0);
        wr(2'd0, 16'b101);
        #1;
        chk(svc_req == 1'b0, "R1 svc_req armed", svc_req, 0);
        begin
            int bad = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); #1;
                if (mem_en || !bus_req) bad++;
            end
            chk(bad == 0, "R3 no memory cycle without grant", bad, 0);
        end
        wr(2'd1, 16'd999); wr(2'd2, 16'd77); #1;
        chk(st_addr == 16'd40, "R9 address write ignored", st_addr, 40);
        chk(st_count == 8'd3, "R9 count write ignored", st_count, 3);
        wr(2'd0, 16'b000); #1;
        chk(!st_enable && !bus_req && !irq && st_count == 8'd3,
            "R9 abort", {st_enable, bus_req, irq, st_count}, 3);

        // R7: zero count arm, then done clear
        wr(2'd2, 16'd0); wr(2'd0, 16'b001); #1;
        chk(irq && !st_enable && !bus_req, "R7 zero count completes", {irq, st_enable, bus_req}, 4);
        wr(2'd0, 16'b000); #1;
        chk(!irq, "R7 done cleared", irq, 0);

        // Sweeps: burst with hold limits, steal in both directions
        for (int n = 1; n <= 5; n++)
            for (int lim = 0; lim <= 3; lim++)
                run_xfer(100 * n + lim, n, lim, 1'b1, ((n + lim) % 2) == 1);
        for (int n = 1; n <= 5; n++)
            for (int d = 0; d <= 1; d++)
                run_xfer(700 + 10 * n, n, 2, 1'b0, d == 1);
        run_xfer(16'hFFFE, 4, 0, 1'b1, 1'b1);

        // R5: higher-priority interrupt forces a one-cycle release
        bus_grant = 1'b1; dev_req = 1'b1;
        wr(2'd1, 16'd300); wr(2'd2, 16'd4); wr(2'd3, 16'd0);
        wr(2'd0, 16'b111);
        moves = 0; done_at = -1;
        for (int k = 0; k < 50; k++) begin
            if (k > 0) @(negedge clk);
            irq_hi = (k == 1);
            #1;
            if (irq) begin done_at = k; break; end
            if (k == 1) chk(!mem_en, "R5 no move under irq_hi", mem_en, 0);
            if (k == 2) chk(!bus_req, "R5 bus released", bus_req, 0);
            if (k == 3) chk(bus_req, "R5 bus re-requested", bus_req, 1);
            if (mem_en) moves++;
        end
        irq_hi = 1'b0;
        chk(done_at == 6, "R5 preempted completion cycle", done_at, 6);
        chk(moves == 4, "R5 words moved", moves, 4);

        // R9 + R7: last word and abort write in the same cycle
        wr(2'd1, 16'd500); wr(2'd2, 16'd1);
        wr(2'd0, 16'b101);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'b000;
        #1;
        chk(mem_en == 1'b1, "R9 word moves in abort cycle", mem_en, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        chk(irq && st_addr == 16'd501 && st_count == 0 && !st_enable,
            "R9 abort coincides with last word", st_addr, 501);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule